// File: doc/BRIEF.md
# Debounced Glitch-Free Clock Stop Controller

This block gates a set of buffered differential clock pairs (a true and a complement leg per pair) under an active-low stop request. The request may change at any moment with no relation to the clock. It is first brought into the clock domain by a flop chain, then debounced: a new level counts only when two consecutive complement-clock rising edges see it. The pair clock is the reference clock divided by two, so every reference edge is a transition of the pair clock.

Each pair has a stoppable bit. Once a stop has been accepted, every stoppable pair freezes on the next edge where its true leg would rise, so the last high phase is a full one. A global park-mode bit chooses how a stopped pair sits. In driven parking, the true leg is held high and the complement leg is released. In floating parking, both legs are released. A per-pair enable overrides everything and releases both legs. Each leg is modelled as a value plus a drive-enable. When the request is withdrawn and the release is accepted, all stopped pairs restart together after a fixed wait, beginning with a high phase of the true leg.

Top module: `clk_stop_ctrl`

## Requirements
- R1: During and right after reset every pair runs with both legs driven, true leg 0 and complement leg 1, and the filtered request reads as released.
- R2: A running, enabled pair drives both legs; the true leg toggles on every reference clock edge and the complement leg is always its inverse.
- R3: A stop-request level passes a two-flop synchronizer and is accepted only when two consecutive complement-clock rising edges sample it unchanged; a low pulse of one or two reference cycles changes no output.
- R4: A pair whose stoppable bit is 0 keeps running while a stop is accepted; clearing the bit of a parked pair restarts it within two reference edges.
- R5: A stoppable pair stops only on an edge where its true leg goes from 0 to 1, so the true leg never shows a high phase shorter than one reference cycle.
- R6: With park-mode 0 a stopped pair drives the true leg at 1 and leaves the complement leg undriven at value 0.
- R7: With park-mode 1 and a stop accepted, a stopped pair leaves both legs undriven at value 0.
- R8: When a pair's enable is 0, both of its legs are undriven at value 0 whatever the request and mode.
- R9: After an accepted release, all stopped pairs restart on the same edge, the first true-rising edge after two more complement-clock rising edges, with the true leg at 1 in the first cycle.
- R10: In park-mode 1, from the accepted release until restart, a stopped pair drives the true leg at 1 with the complement leg undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| park_float | input | 1 | Park mode: 0 driven true-high, 1 both legs released |
| stoppable | input | N_PAIRS | Per-pair: 1 lets the pair be stopped |
| pair_en | input | N_PAIRS | Per-pair enable; 0 releases both legs |
| dif_t | output | N_PAIRS | True leg value |
| dif_t_oe | output | N_PAIRS | True leg drive-enable |
| dif_c | output | N_PAIRS | Complement leg value |
| dif_c_oe | output | N_PAIRS | Complement leg drive-enable |

## Verification
Two events can fall on one edge: a pair's enable or stoppable bit can change in the same cycle that the filtered request parks or restarts that pair, and a new request can arrive while the restart wait is still counting. A long randomized phase toggles the request, the mode, the stoppable bits and the enables on unrelated short intervals. This makes such collisions frequent. A behavioural model in the bench predicts all four legs of every pair and is compared on every cycle. Directed phases also measure the stop edge, the parking states and the restart edge on their own.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    typedef struct packed {
        logic t;
        logic t_oe;
        logic c;
        logic c_oe;
    } pair_drv_t;

    localparam pair_drv_t PAIR_OFF = '{t: 1'b0, t_oe: 1'b0, c: 1'b0, c_oe: 1'b0};

    // Leg values for one pair from its run state and the global controls.
    function automatic pair_drv_t drive_pair(
        input logic en,
        input logic running,
        input logic ph,
        input logic park_float,
        input logic released
    );
        pair_drv_t d;
        d = PAIR_OFF;
        if (en) begin
            if (running) begin
                d.t = ph;
                d.t_oe = 1'b1;
                d.c = ~ph;
                d.c_oe = 1'b1;
            end else if (!park_float || released) begin
                d.t = 1'b1;
                d.t_oe = 1'b1;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/clk_stop_filter.sv
module clk_stop_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic samp_en,
    output logic acc_n,
    output logic release_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic                   prev_q;
    logic                   acc_q;

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            acc_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], req_n};
            if (samp_en) begin
                prev_q <= sync_lvl;
                if (sync_lvl == prev_q) begin
                    acc_q <= sync_lvl;
                end
            end
        end
    end

    assign acc_n       = acc_q;
    assign release_evt = samp_en && sync_lvl && prev_q && !acc_q;
endmodule

// File: rtl/clk_stop_resume_timer.sv
module clk_stop_resume_timer #(
    parameter int RESUME_EDGES = 2,
    parameter int CNT_W = $clog2(RESUME_EDGES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic load,
    input  logic armed,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(RESUME_EDGES);
        end else if (samp_en && armed && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/clk_stop_pair_gate.sv
module clk_stop_pair_gate
    import clk_stop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ph,
    input  logic      rise_evt,
    input  logic      stop_go,
    input  logic      resume_go,
    input  logic      stoppable,
    input  logic      en,
    input  logic      park_float,
    input  logic      released,
    output pair_drv_t drv
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b1;
        end else if (rise_evt && !stoppable) begin
            run_q <= 1'b1;
        end else if (run_q && stop_go) begin
            run_q <= 1'b0;
        end else if (!run_q && resume_go) begin
            run_q <= 1'b1;
        end
    end

    assign drv = drive_pair(en, run_q, ph, park_float, released);
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int N_PAIRS      = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int RESUME_EDGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_req_n,
    input  logic               park_float,
    input  logic [N_PAIRS-1:0] stoppable,
    input  logic [N_PAIRS-1:0] pair_en,
    output logic [N_PAIRS-1:0] dif_t,
    output logic [N_PAIRS-1:0] dif_t_oe,
    output logic [N_PAIRS-1:0] dif_c,
    output logic [N_PAIRS-1:0] dif_c_oe
);
    localparam int CNT_W = $clog2(RESUME_EDGES + 1);

    logic ph_q;
    logic samp_en;
    logic rise_evt;
    logic acc_n;
    logic release_evt;
    logic wait_done;
    logic stop_go;
    logic resume_go;

    // Pair clock: reference divided by two; true leg equals ph_q.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    assign samp_en  = ph_q;   // complement leg rises on this edge
    assign rise_evt = ~ph_q;  // true leg rises on this edge

    clk_stop_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk(clk), .rst(rst), .req_n(stop_req_n), .samp_en(samp_en),
        .acc_n(acc_n), .release_evt(release_evt)
    );

    clk_stop_resume_timer #(.RESUME_EDGES(RESUME_EDGES), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .samp_en(samp_en), .load(release_evt),
        .armed(acc_n), .done(wait_done)
    );

    assign stop_go   = rise_evt && !acc_n;
    assign resume_go = rise_evt && acc_n && wait_done;

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        pair_drv_t drv;
        clk_stop_pair_gate u_gate (
            .clk(clk), .rst(rst), .ph(ph_q), .rise_evt(rise_evt),
            .stop_go(stop_go), .resume_go(resume_go), .stoppable(stoppable[g]),
            .en(pair_en[g]), .park_float(park_float), .released(acc_n),
            .drv(drv)
        );
        assign dif_t[g]    = drv.t;
        assign dif_t_oe[g] = drv.t_oe;
        assign dif_c[g]    = drv.c;
        assign dif_c_oe[g] = drv.c_oe;
    end
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
    parameter int N_PAIRS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_PAIRS-1:0] stoppable,
    input logic [N_PAIRS-1:0] pair_en,
    input logic [N_PAIRS-1:0] dif_t,
    input logic [N_PAIRS-1:0] dif_t_oe,
    input logic [N_PAIRS-1:0] dif_c,
    input logic [N_PAIRS-1:0] dif_c_oe
);
    for (genvar i = 0; i < N_PAIRS; i++) begin : g_chk
        p_oe_override_r8: assert property (@(posedge clk) disable iff (rst)
            !pair_en[i] |-> (!dif_t_oe[i] && !dif_c_oe[i]));

        p_pair_complement_r2: assert property (@(posedge clk) disable iff (rst)
            dif_c_oe[i] |-> (dif_t_oe[i] && (dif_c[i] != dif_t[i])));

        p_park_true_high_r6: assert property (@(posedge clk) disable iff (rst)
            (dif_t_oe[i] && !dif_c_oe[i]) |-> dif_t[i]);

        p_park_entry_r5: assert property (@(posedge clk) disable iff (rst)
            (pair_en[i] && $past(pair_en[i]) && $past(dif_c_oe[i]) && !dif_c_oe[i])
            |-> !$past(dif_t[i]));

        p_free_run_r4: assert property (@(posedge clk) disable iff (rst)
            (pair_en[i] && !stoppable[i] && !$past(stoppable[i]) && !$past(stoppable[i], 2))
            |-> dif_c_oe[i]);
    end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_PAIRS(N_PAIRS)) u_chk (
    .clk(clk), .rst(rst), .stoppable(stoppable), .pair_en(pair_en),
    .dif_t(dif_t), .dif_t_oe(dif_t_oe), .dif_c(dif_c), .dif_c_oe(dif_c_oe)
);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req_n = 1'b1;
    logic park_float = 1'b0;
    logic [N-1:0] stoppable = '0;
    logic [N-1:0] pair_en = '1;
    logic [N-1:0] dif_t, dif_t_oe, dif_c, dif_c_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    clk_stop_ctrl #(.N_PAIRS(N)) u_dut (
        .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .park_float(park_float),
        .stoppable(stoppable), .pair_en(pair_en),
        .dif_t(dif_t), .dif_t_oe(dif_t_oe), .dif_c(dif_c), .dif_c_oe(dif_c_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_ph, m_s1, m_s2, m_prev, m_acc, m_cnt;
    int m_run [N];

    always @(posedge clk) begin
        int o_ph, o_s2, o_prev, o_acc, o_cnt;
        if (rst) begin
            m_ph = 0; m_s1 = 1; m_s2 = 1; m_prev = 1; m_acc = 1; m_cnt = 0;
            for (int i = 0; i < N; i++) m_run[i] = 1;
        end else begin
            o_ph = m_ph; o_s2 = m_s2; o_prev = m_prev; o_acc = m_acc; o_cnt = m_cnt;
            m_s2 = m_s1;
            m_s1 = int'(stop_req_n);
            if (o_ph == 1) begin
                m_prev = o_s2;
                if (o_s2 == o_prev) m_acc = o_s2;
            end
            if (o_ph == 1 && o_s2 == 1 && o_prev == 1 && o_acc == 0) m_cnt = 2;
            else if (o_ph == 1 && o_acc == 1 && o_cnt > 0) m_cnt = o_cnt - 1;
            for (int i = 0; i < N; i++) begin
                if (o_ph == 0) begin
                    if (!stoppable[i]) m_run[i] = 1;
                    else if (m_run[i] == 1 && o_acc == 0) m_run[i] = 0;
                    else if (m_run[i] == 0 && o_acc == 1 && o_cnt == 0) m_run[i] = 1;
                end
            end
            m_ph = 1 - o_ph;
        end
    end

    function automatic logic [3:0] model_pair(input int i);
        if (!pair_en[i]) return 4'b0000;             // {t, t_oe, c, c_oe}
        if (m_run[i] == 1) return {m_ph[0], 1'b1, ~m_ph[0], 1'b1};
        if (!park_float || m_acc == 1) return 4'b1100;
        return 4'b0000;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                logic [3:0] act, exp;
                act = {dif_t[i], dif_t_oe[i], dif_c[i], dif_c_oe[i]};
                exp = model_pair(i);
                chk(act == exp, cur_req, $sformatf("pair %0d legs {t,t_oe,c,c_oe}", i),
                    int'(act), int'(exp));
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R1", "watchdog expired", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit seen;
        int lat;
        step(4);
        // R1: reset state while still in reset
        chk(dif_t == '0 && dif_t_oe == '1, "R1", "true legs at reset", int'(dif_t), 0);
        chk(dif_c == '1 && dif_c_oe == '1, "R1", "complement legs at reset", int'(dif_c), 15);
        rst = 1'b0;

        // R2: free running toggles each reference edge
        cur_req = "R2";
        step(5);
        begin
            logic a;
            a = dif_t[0];
            step(1);
            chk(dif_t[0] != a && dif_c[0] == ~dif_t[0], "R2", "true toggles", int'(dif_t[0]), int'(~a));
        end

        // R3: short pulses ignored
        cur_req = "R3";
        stoppable = 4'b0101;
        seen = 1'b0;
        stop_req_n = 1'b0; step(1); stop_req_n = 1'b1;
        for (int k = 0; k < 12; k++) begin step(1); if (dif_c_oe != '1) seen = 1'b1; end
        stop_req_n = 1'b0; step(2); stop_req_n = 1'b1;
        for (int k = 0; k < 12; k++) begin step(1); if (dif_c_oe != '1) seen = 1'b1; end
        chk(!seen, "R3", "short pulse changed outputs", int'(seen), 0);

        // R5/R6/R4: long stop, driven parking
        cur_req = "R5";
        stop_req_n = 1'b0;
        seen = 1'b0;
        begin
            logic pt;
            logic pc;
            pt = dif_t[0]; pc = dif_c_oe[0];
            for (int k = 0; k < 16; k++) begin
                step(1);
                if (pc && !dif_c_oe[0]) chk(pt == 1'b0 && dif_t[0], "R5", "true before stop", int'(pt), 0);
                pt = dif_t[0]; pc = dif_c_oe[0];
            end
        end
        chk(dif_t[0] && dif_t_oe[0] && !dif_c_oe[0] && !dif_c[0], "R6", "pair 0 parked",
            int'({dif_t[0], dif_t_oe[0], dif_c[0], dif_c_oe[0]}), 12);
        chk(dif_c_oe[1] && dif_c_oe[3], "R4", "non-stoppable pairs running",
            int'({dif_c_oe[3], dif_c_oe[1]}), 3);

        // R7: floating park
        cur_req = "R7";
        park_float = 1'b1;
        step(2);
        chk({dif_t[2], dif_t_oe[2], dif_c[2], dif_c_oe[2]} == 4'b0000, "R7", "pair 2 floating",
            int'({dif_t[2], dif_t_oe[2], dif_c[2], dif_c_oe[2]}), 0);

        // R8: enable override on running pair
        cur_req = "R8";
        pair_en[1] = 1'b0;
        step(1);
        chk({dif_t[1], dif_t_oe[1], dif_c[1], dif_c_oe[1]} == 4'b0000, "R8", "disabled pair 1",
            int'({dif_t[1], dif_t_oe[1], dif_c[1], dif_c_oe[1]}), 0);
        pair_en[1] = 1'b1;
        step(2);

        // R9/R10: release and joint restart
        cur_req = "R9";
        stop_req_n = 1'b1;
        seen = 1'b0;
        lat = -1;
        for (int k = 1; k <= 20 && lat < 0; k++) begin
            step(1);
            if (dif_t_oe[0] && dif_t[0] && !dif_c_oe[0]) seen = 1'b1;
            if (dif_c_oe[0]) begin
                lat = k;
                chk(dif_c_oe[2] == 1'b1, "R9", "pairs restart together", int'(dif_c_oe[2]), 1);
                chk(dif_t[0] == 1'b1, "R9", "restart with true high", int'(dif_t[0]), 1);
            end
        end
        chk(lat >= 6 && lat <= 14, "R9", "restart latency in cycles", lat, 10);
        chk(seen, "R10", "true driven high before restart", int'(seen), 1);

        // R4: clearing stoppable of a parked pair
        cur_req = "R4";
        park_float = 1'b0;
        stop_req_n = 1'b0;
        step(16);
        chk(!dif_c_oe[2], "R4", "pair 2 parked before clear", int'(dif_c_oe[2]), 0);
        stoppable[2] = 1'b0;
        step(2);
        chk(dif_c_oe[2], "R4", "pair 2 restarted after clear", int'(dif_c_oe[2]), 1);
        stop_req_n = 1'b1;
        stoppable = 4'b0101;
        step(20);

        // randomized collisions, judged by the reference each cycle
        cur_req = "R9";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r < 3) stop_req_n = ~stop_req_n;
            else if (r == 3) park_float = ~park_float;
            else if (r == 4) stoppable = 4'($urandom_range(0, 15));
            else if (r == 5) pair_en = 4'($urandom_range(0, 15)) | 4'b1000;
            step($urandom_range(1, 4));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule